// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock by a programmable ratio using the pulse-swallow scheme. A dual-modulus prescaler divides by M or by M+1. A down-counting swallow counter steers the prescaler's modulus control. A down-counting main counter counts prescaler output pulses and ends each divide cycle. The result is one output pulse, `fp_o`, every M×N+A fast-clock cycles. This pulse feeds a phase comparator as the divided-down feedback frequency.

The main count N, the swallow count A and the modulus-pair select are sampled only when a divide cycle finishes. A change made in the middle of a cycle therefore never produces a shortened or stretched output period. A combinational flag reports a programmed setting that breaks the pulse-swallow rules.

Top module: `ps_feedback_divider`

## Requirements
- R1: While `rst_ni` is low, `fp_o` is low.
- R2: With `pair_sel_i` high, the prescaler pair is MOD_LO/MOD_LO+1. For legal N and A, consecutive `fp_o` pulses are MOD_LO×N+A clock cycles apart.
- R3: With `pair_sel_i` low, the prescaler pair is MOD_HI/MOD_HI+1. For legal N and A, the pulse spacing is MOD_HI×N+A clock cycles.
- R4: With A = 0, the prescaler divides by M for the whole cycle, so the spacing is exactly M×N.
- R5: Each `fp_o` pulse is high for exactly one clock cycle.
- R6: `n_i`, `a_i` and `pair_sel_i` are sampled only at the clock edge that ends a divide cycle. A change made mid-cycle leaves the current period unchanged and sets the following one.
- R7: `cfg_err_o` is high exactly when `n_i` < 3 or `a_i` ≥ `n_i`, and low otherwise.
- R8: The extreme legal settings N = 2047 and A = 127 give a spacing of M×2047+127 for both pairs.
- R9: After reset is released, the first `fp_o` pulse appears on clock edge M×N+A+1. The first edge after release loads the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| n_i | input | N_W (11) | Main counter value N |
| a_i | input | A_W (7) | Swallow counter value A |
| pair_sel_i | input | 1 | Prescaler pair select: 1 = MOD_LO/MOD_LO+1, 0 = MOD_HI/MOD_HI+1 |
| fp_o | output | 1 | Divided output pulse, one clock wide |
| cfg_err_o | output | 1 | Illegal setting flag (N < 3 or A ≥ N) |

## Verification
Two events can fall on the same clock edge: the end of a divide cycle, which fires `fp_o`, and the load of new settings. A setting change also interacts with the prescaler's switch from M+1 to M. The bench changes N, A and the pair select a few cycles after a pulse. It then checks that the next interval still has the old length and the one after has the new length. Every interval is checked against M×N+A, computed in the bench. This is done over a sweep of all A < N for small N in both pairs, with a small prescaler configuration.

// File: rtl/ps_div_pkg.sv
package ps_div_pkg;
  typedef enum logic {
    PAIR_HI = 1'b0,
    PAIR_LO = 1'b1
  } pair_e;
  localparam int unsigned MIN_N = 3;
endpackage

// File: rtl/ps_dual_mod.sv
module ps_dual_mod #(
  parameter int unsigned MOD_LO = 32,
  parameter int unsigned MOD_HI = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pair_lo_i,
  input  logic plus_one_i,
  output logic tick_o
);
  localparam int unsigned PC_W = $clog2(MOD_HI + 2);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] term;

  always_comb begin
    base   = pair_lo_i ? PC_W'(MOD_LO - 1) : PC_W'(MOD_HI - 1);
    term   = base + PC_W'(plus_one_i);
    tick_o = run_i && (pc_q == term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (!run_i)  pc_q <= '0;
    else if (tick_o)  pc_q <= '0;
    else              pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/ps_cycle_ctrl.sv
module ps_cycle_ctrl
  import ps_div_pkg::*;
#(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           pair_sel_i,
  input  logic           tick_i,
  output logic           run_o,
  output logic           pair_lo_o,
  output logic           plus_one_o,
  output logic           fp_o
);
  logic [N_W-1:0] main_q;
  logic [A_W-1:0] swal_q;
  pair_e          pair_q;
  logic           run_q;
  logic           last;
  logic           load;

  always_comb begin
    last       = (main_q == N_W'(1));
    load       = !run_q || (tick_i && last);
    plus_one_o = (swal_q != '0);
    run_o      = run_q;
    pair_lo_o  = (pair_q == PAIR_LO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      main_q <= '0;
      swal_q <= '0;
      pair_q <= PAIR_HI;
      fp_o   <= 1'b0;
    end else begin
      run_q <= 1'b1;
      fp_o  <= run_q && tick_i && last;
      if (load) begin
        main_q <= n_i;
        swal_q <= a_i;
        pair_q <= pair_sel_i ? PAIR_LO : PAIR_HI;
      end else if (tick_i) begin
        main_q <= main_q - 1'b1;
        if (swal_q != '0) swal_q <= swal_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps_cfg_check.sv
module ps_cfg_check
  import ps_div_pkg::*;
#(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  output logic           err_o
);
  localparam int unsigned CW = (N_W > A_W) ? N_W : A_W;
  logic [CW-1:0] n_ext, a_ext;
  always_comb begin
    n_ext = CW'(n_i);
    a_ext = CW'(a_i);
    err_o = (n_ext < CW'(MIN_N)) || (a_ext >= n_ext);
  end
endmodule

// File: rtl/ps_feedback_divider.sv
module ps_feedback_divider #(
  parameter int unsigned MOD_LO = 32,
  parameter int unsigned MOD_HI = 64,
  parameter int unsigned N_W    = 11,
  parameter int unsigned A_W    = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           pair_sel_i,
  output logic           fp_o,
  output logic           cfg_err_o
);
  logic run, pair_lo, plus_one, tick;

  ps_dual_mod #(.MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .pair_lo_i(pair_lo), .plus_one_i(plus_one), .tick_o(tick)
  );

  ps_cycle_ctrl #(.N_W(N_W), .A_W(A_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i),
    .pair_sel_i(pair_sel_i), .tick_i(tick), .run_o(run),
    .pair_lo_o(pair_lo), .plus_one_o(plus_one), .fp_o(fp_o)
  );

  ps_cfg_check #(.N_W(N_W), .A_W(A_W)) u_chk_cfg (
    .n_i(n_i), .a_i(a_i), .err_o(cfg_err_o)
  );
endmodule

// File: rtl/ps_feedback_divider_chk.sv
module ps_feedback_divider_chk #(
  parameter int unsigned MOD_LO = 32,
  parameter int unsigned N_W    = 11,
  parameter int unsigned A_W    = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N_W-1:0] n_i,
  input logic [A_W-1:0] a_i,
  input logic           fp_o,
  input logic           cfg_err_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (fp_o) begin
        gap_q  <= 32'd1;
        seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always_comb begin
    a_r1_quiet_reset: assert (rst_ni || !fp_o);
  end

  a_r5_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  a_r2_gap_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_o && seen_q) |-> (gap_q >= 32'(MOD_LO)));

  a_r7_small_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i < N_W'(3)) |-> cfg_err_o);

  a_r7_a_not_below_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (N_W'(a_i) >= n_i) |-> cfg_err_o);
endmodule

bind ps_feedback_divider ps_feedback_divider_chk #(
  .MOD_LO(MOD_LO), .N_W(N_W), .A_W(A_W)
) u_prop (
  .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i),
  .fp_o(fp_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_ps_feedback_divider.sv
module tb_ps_feedback_divider;
  localparam int unsigned MOD_LO = 4;
  localparam int unsigned MOD_HI = 8;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] n_v = 11'd6;
  logic [6:0]  a_v = 7'd1;
  logic        sel_v = 1'b1;
  logic        fp, err;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ps_feedback_divider #(.MOD_LO(MOD_LO), .MOD_HI(MOD_HI), .N_W(11), .A_W(7)) dut (
    .clk_i(clk), .rst_ni(rst_n), .n_i(n_v), .a_i(a_v),
    .pair_sel_i(sel_v), .fp_o(fp), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fp();
    int k = 0;
    do begin @(negedge clk); k++; end while (!fp && k < LIMIT);
    if (!fp) chk(0, "watchdog", k, LIMIT);
  endtask

  // interval from the current pulse to the next one, with width check
  task automatic interval(input int exp, input string req);
    int k = 0;
    bit wide = 0;
    do begin
      @(negedge clk); k++;
      if (k == 1 && fp) wide = 1;
    end while (!fp && k < LIMIT);
    chk(!wide, "R5", int'(wide), 0);
    chk(k == exp, req, k, exp);
  endtask

  function automatic int period(input int s, input int n, input int a);
    return (s ? MOD_LO : MOD_HI) * n + a;
  endfunction

  initial begin
    // R1: reset holds output low
    repeat (3) @(negedge clk);
    chk(fp == 1'b0, "R1", int'(fp), 0);
    // R9: first pulse after release on edge T+1
    begin
      int c0, k;
      rst_n = 1'b1;
      c0 = cyc; k = 0;
      do begin @(negedge clk); k++; end while (!fp && k < LIMIT);
      chk((cyc - c0) == period(1, 6, 1) + 1, "R9", cyc - c0, period(1, 6, 1) + 1);
    end

    // R2/R3/R4 sweep over all legal A for small N, both pairs
    for (int s = 0; s < 2; s++)
      for (int n = 3; n <= 12; n++)
        for (int a = 0; a < n; a++) begin
          n_v = 11'(n); a_v = 7'(a); sel_v = s[0];
          #1 chk(err == 1'b0, "R7", int'(err), 0);
          wait_fp();
          interval(period(s, n, a), a == 0 ? "R4" : (s ? "R2" : "R3"));
        end

    // R6: mid-cycle change applies one period later
    @(negedge clk);
    n_v = 11'd5; a_v = 7'd2; sel_v = 1'b1;
    wait_fp();
    wait_fp();
    repeat (3) @(negedge clk);
    n_v = 11'd7; a_v = 7'd3; sel_v = 1'b0;
    wait_fp();
    interval(period(0, 7, 3), "R6");
    // the interval measured above started at the boundary that loaded new values;
    // check that the boundary before it still used the old ratio
    n_v = 11'd5; a_v = 7'd2; sel_v = 1'b1;
    wait_fp();
    begin
      int k = 0;
      repeat (3) begin @(negedge clk); k++; end
      n_v = 11'd9; a_v = 7'd0; sel_v = 1'b0;
      do begin @(negedge clk); k++; end while (!fp && k < LIMIT);
      chk(k == period(1, 5, 2), "R6", k, period(1, 5, 2));
    end
    interval(period(0, 9, 0), "R6");

    // R8: extreme settings
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      n_v = 11'd2047; a_v = 7'd127; sel_v = s[0];
      #1 chk(err == 1'b0, "R8", int'(err), 0);
      wait_fp();
      interval(period(s, 2047, 127), "R8");
    end

    // R7: illegal settings raise the flag
    @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      n_v = 11'(n); a_v = 7'd0;
      #1 chk(err == 1'b1, "R7", int'(err), 1);
    end
    n_v = 11'd10; a_v = 7'd10;
    #1 chk(err == 1'b1, "R7", int'(err), 1);
    n_v = 11'd10; a_v = 7'd15;
    #1 chk(err == 1'b1, "R7", int'(err), 1);
    n_v = 11'd10; a_v = 7'd9;
    #1 chk(err == 1'b0, "R7", int'(err), 0);
    n_v = 11'd3; a_v = 7'd127;
    #1 chk(err == 1'b1, "R7", int'(err), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      chk(0, "watchdog", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule